// File: doc/BRIEF.md
# Parity-Checked Direct-Mapped Instruction Cache

This block is a small read-only instruction cache that sits between a fetch unit and the next memory level. Each fetch returns one naturally aligned 16-byte chunk. The block holds 64 such lines in a direct-mapped arrangement, and each line has a tag and a valid bit. The core never writes the cache, so the block has no dirty state and no write-back path. One lookup port serves instruction fetch alone.

Each 8-byte half of a stored chunk carries one even-parity bit, computed when the line is filled. A lookup that matches the tag but fails the parity check is not corrected. The block counts the error, invalidates the line and fetches the clean copy again through the same request/response refill port that handles ordinary misses. A fault-injection input flips one stored data bit so that upsets can be modelled.

Top module: `ifp_cache`

## Requirements
- R1: After reset every valid bit is clear, `refill_req` is low and `perr_count` is 0. The first fetch to any line misses.
- R2: When a fetch misses, `fetch_ready` stays low in that cycle. From the next cycle, `refill_req` is high with `refill_addr` equal to the fetch address with bits [3:0] zeroed. It stays high with a stable address until `refill_valid` is seen.
- R3: In the cycle after `refill_valid` is seen while a refill is outstanding, `refill_req` is low. A fetch to the refilled address then completes in that cycle, with `fetch_ready` high and `fetch_data` equal to the supplied chunk.
- R4: Address bits [3:0] are ignored on lookup. Any address inside a resident chunk hits and returns the whole chunk.
- R5: The line index is address bits [9:4] and the tag is bits [31:10]. A fetch whose index matches a resident line but whose tag differs misses, and its refill replaces that line.
- R6: `fetch_ready` is high only when `fetch_valid` is high, no refill is outstanding, and the lookup hits with good parity.
- R7: Bit k of a chunk for k in 0..63 belongs to the lower half, and bits 64..127 belong to the upper half. Each half has one even-parity bit. A hit whose stored data fails either parity check is not accepted. It raises `perr_count` by exactly one and starts a refetch of that line as in R2.
- R8: After a parity refetch, the clean chunk from the refill port is returned to the fetch unit.
- R9: A pulse on `inj_valid` flips stored data bit `inj_bit` of line `inj_index`. If both halves of a line carry a single flipped bit, one error is counted.
- R10: Two flipped bits in the same half cancel in that half's parity. Such a line hits and returns the corrupted data, and `perr_count` does not change.
- R11: Only one refill is outstanding at a time. While a refill is outstanding, changes on the fetch inputs do not alter `refill_addr` and do not raise `fetch_ready`.
- R12: A `refill_valid` pulse with no refill outstanding is ignored and writes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch accepted, data valid this cycle |
| fetch_data | output | 128 | Fetched chunk |
| refill_req | output | 1 | Refill request to next level |
| refill_addr | output | 32 | Aligned refill address |
| refill_valid | input | 1 | Refill data pulse |
| refill_data | input | 128 | Refill chunk |
| inj_valid | input | 1 | Flip one stored data bit |
| inj_index | input | 6 | Line to corrupt |
| inj_bit | input | 7 | Bit position within the chunk |
| perr_count | output | 8 | Number of parity errors detected |

## Verification
The hardest state to reach from the ports is a resident line whose stored bits disagree with their parity. Refills always write consistent parity. The bench therefore loads a line and uses the injection input to flip chosen bits in one half, in both halves, or twice in the same half. The next fetch then shows a detected refetch with a counter step, or a silent pass of corrupted data. Stray refill pulses and address changes during a long refill wait are driven the same way, and a later fetch shows that they left no trace.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINES      = 64;
    localparam int unsigned DEF_LINE_BYTES = 16;
    localparam int unsigned DEF_PAR_BYTES  = 8;
    localparam int unsigned DEF_CNT_W      = 8;

    typedef enum logic {
        ST_LOOK = 1'b0,
        ST_FILL = 1'b1
    } ifp_state_e;
endpackage

// File: rtl/ifp_parity_gen.sv
module ifp_parity_gen #(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned SEG_W  = 64,
    localparam int unsigned PAR_W = DATA_W / SEG_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  par
);
    for (genvar g = 0; g < PAR_W; g++) begin : g_seg
        // even parity: the segment plus its bit hold an even count of ones
        assign par[g] = ^data[g*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/ifp_line_store.sv
module ifp_line_store #(
    parameter int unsigned LINES  = 64,
    parameter int unsigned TAG_W  = 22,
    parameter int unsigned DATA_W = 128,
    parameter int unsigned PAR_W  = 2,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic [PAR_W-1:0]  rd_par,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAR_W-1:0]  wr_par,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit
);
    logic [LINES-1:0]  vld_d, vld_q;
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_d [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [PAR_W-1:0]  par_d  [LINES];
    logic [PAR_W-1:0]  par_q  [LINES];

    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < LINES; i++) begin
            tag_d[i]  = tag_q[i];
            data_d[i] = data_q[i];
            par_d[i]  = par_q[i];
        end
        if (inj_en) begin
            data_d[inj_idx][inj_bit] = ~data_q[inj_idx][inj_bit];
        end
        if (inv_en) begin
            vld_d[inv_idx] = 1'b0;
        end
        if (wr_en) begin
            vld_d[wr_idx]  = 1'b1;
            tag_d[wr_idx]  = wr_tag;
            data_d[wr_idx] = wr_data;
            par_d[wr_idx]  = wr_par;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
        for (int i = 0; i < LINES; i++) begin
            tag_q[i]  <= tag_d[i];
            data_q[i] <= data_d[i];
            par_q[i]  <= par_d[i];
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];
    assign rd_par  = par_q[rd_idx];
endmodule

// File: rtl/ifp_refill_fsm.sv
module ifp_refill_fsm
    import ifp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              look_hit,
    input  logic              par_ok,
    input  logic              refill_valid,
    output logic              fetch_ready,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    output logic              wr_en,
    output logic              inv_en,
    output logic [CNT_W-1:0]  perr_count
);
    typedef struct packed {
        ifp_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        fetch_ready = 1'b0;
        wr_en       = 1'b0;
        inv_en      = 1'b0;
        case (ctl_q.st)
            ST_LOOK: begin
                if (fetch_valid) begin
                    if (look_hit && par_ok) begin
                        fetch_ready = 1'b1;
                    end else begin
                        ctl_d.st   = ST_FILL;
                        ctl_d.addr = line_addr;
                        if (look_hit) begin
                            inv_en    = 1'b1;
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (refill_valid) begin
                    wr_en    = 1'b1;
                    ctl_d.st = ST_LOOK;
                end
            end
            default: ctl_d.st = ST_LOOK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_LOOK;
            ctl_q.addr <= '0;
            ctl_q.cnt  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign refill_req  = (ctl_q.st == ST_FILL);
    assign refill_addr = ctl_q.addr;
    assign perr_count  = ctl_q.cnt;
endmodule

// File: rtl/ifp_cache.sv
module ifp_cache
    import ifp_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINES      = DEF_LINES,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned PAR_BYTES  = DEF_PAR_BYTES,
    parameter int unsigned CNT_W      = DEF_CNT_W,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = $clog2(LINES),
    localparam int unsigned TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned DATA_W    = LINE_BYTES * 8,
    localparam int unsigned SEG_W     = PAR_BYTES * 8,
    localparam int unsigned PAR_W     = LINE_BYTES / PAR_BYTES,
    localparam int unsigned BIT_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_valid,
    input  logic [DATA_W-1:0] refill_data,
    input  logic              inj_valid,
    input  logic [IDX_W-1:0]  inj_index,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic [CNT_W-1:0]  perr_count
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

    logic [ADDR_W-1:0] line_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic [PAR_W-1:0]  rd_par;
    logic [PAR_W-1:0]  chk_par;
    logic [PAR_W-1:0]  fill_par;
    logic              look_hit;
    logic              par_ok;
    logic              wr_en;
    logic              inv_en;

    assign line_addr = fetch_addr & ALIGN_MASK;
    assign look_idx  = line_addr[OFF_W +: IDX_W];
    assign look_tag  = line_addr[ADDR_W-1 -: TAG_W];

    ifp_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .PAR_W  (PAR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (look_idx),
        .rd_vld  (rd_vld),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .wr_en   (wr_en),
        .wr_idx  (refill_addr[OFF_W +: IDX_W]),
        .wr_tag  (refill_addr[ADDR_W-1 -: TAG_W]),
        .wr_data (refill_data),
        .wr_par  (fill_par),
        .inv_en  (inv_en),
        .inv_idx (look_idx),
        .inj_en  (inj_valid),
        .inj_idx (inj_index),
        .inj_bit (inj_bit)
    );

    ifp_parity_gen #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_par_fill (
        .data (refill_data),
        .par  (fill_par)
    );

    ifp_parity_gen #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_par_look (
        .data (rd_data),
        .par  (chk_par)
    );

    assign look_hit = rd_vld && (rd_tag == look_tag);
    assign par_ok   = (chk_par == rd_par);

    ifp_refill_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .line_addr    (line_addr),
        .look_hit     (look_hit),
        .par_ok       (par_ok),
        .refill_valid (refill_valid),
        .fetch_ready  (fetch_ready),
        .refill_req   (refill_req),
        .refill_addr  (refill_addr),
        .wr_en        (wr_en),
        .inv_en       (inv_en),
        .perr_count   (perr_count)
    );

    assign fetch_data = rd_data;
endmodule

// File: rtl/ifp_cache_chk.sv
module ifp_cache_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic              refill_req,
    input logic [ADDR_W-1:0] refill_addr,
    input logic              refill_valid,
    input logic [CNT_W-1:0]  perr_count
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !refill_valid |=> refill_req && $stable(refill_addr));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (refill_addr[OFF_W-1:0] == '0));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && refill_valid |=> !refill_req);

    // R6
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_valid && !refill_req);

    // R7
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !fetch_ready && !refill_req |=> refill_req);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (perr_count == $past(perr_count)) ||
                 (perr_count == $past(perr_count) + 1'b1));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> $stable(perr_count));
endmodule

bind ifp_cache ifp_cache_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
) u_ifp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_ready  (fetch_ready),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .refill_valid (refill_valid),
    .perr_count   (perr_count)
);

// File: tb/test_ifp_cache.sv
module test_ifp_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_ready;
    logic [127:0] fetch_data;
    logic         refill_req;
    logic [31:0]  refill_addr;
    logic         refill_valid = 1'b0;
    logic [127:0] refill_data = '0;
    logic         inj_valid = 1'b0;
    logic [5:0]   inj_index = '0;
    logic [6:0]   inj_bit = '0;
    logic [7:0]   perr_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ifp_cache i_ifp_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .fetch_ready  (fetch_ready),
        .fetch_data   (fetch_data),
        .refill_req   (refill_req),
        .refill_addr  (refill_addr),
        .refill_valid (refill_valid),
        .refill_data  (refill_data),
        .inj_valid    (inj_valid),
        .inj_index    (inj_index),
        .inj_bit      (inj_bit),
        .perr_count   (perr_count)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input int s);
        logic [31:0] v;
        v = 32'(s);
        return {32'hA5A5_0000 ^ v, 32'h1357_9BDF ^ (v * 32'd7), 32'hC0DE_0000 | v, v * 32'h0101_0101};
    endfunction

    // miss, optional long wait, refill, then hit; exp_cnt checked after the miss
    task automatic fill(input logic [31:0] a, input logic [127:0] d, input int wait_cyc, input string req);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        #2;
        chk(!fetch_ready, req, 128'(fetch_ready), 128'(0));
        @(negedge clk); #2;
        chk(refill_req, "R2", 128'(refill_req), 128'(1));
        chk(refill_addr == {a[31:4], 4'h0}, "R2", 128'(refill_addr), 128'({a[31:4], 4'h0}));
        chk(perr_count == 8'(exp_cnt), req, 128'(perr_count), 128'(exp_cnt));
        for (int i = 0; i < wait_cyc; i++) begin
            fetch_addr = a ^ 32'h0001_0040;
            @(negedge clk); #2;
            chk(refill_req && refill_addr == {a[31:4], 4'h0}, "R11", 128'(refill_addr), 128'({a[31:4], 4'h0}));
            chk(!fetch_ready, "R11", 128'(fetch_ready), 128'(0));
        end
        fetch_addr   = a;
        refill_valid = 1'b1;
        refill_data  = d;
        @(negedge clk);
        refill_valid = 1'b0;
        refill_data  = '0;
        #2;
        chk(!refill_req, "R3", 128'(refill_req), 128'(0));
        chk(fetch_ready && fetch_data == d, "R3", fetch_data, d);
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic hit(input logic [31:0] a, input logic [127:0] d, input string req);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        #2;
        chk(fetch_ready, req, 128'(fetch_ready), 128'(1));
        chk(fetch_data == d, req, fetch_data, d);
        chk(perr_count == 8'(exp_cnt), req, 128'(perr_count), 128'(exp_cnt));
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic inject(input logic [31:0] a, input int b);
        @(negedge clk);
        inj_valid = 1'b1;
        inj_index = a[9:4];
        inj_bit   = 7'(b);
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic t_reset;
        #2;
        chk(!refill_req, "R1", 128'(refill_req), 128'(0));
        chk(perr_count == 8'd0, "R1", 128'(perr_count), 128'(0));
        chk(!fetch_ready, "R6", 128'(fetch_ready), 128'(0));
    endtask

    task automatic t_cold;
        fill(32'h0000_1234, mk(1), 0, "R1");
        hit(32'h0000_1230, mk(1), "R4");
        hit(32'h0000_123F, mk(1), "R4");
    endtask

    task automatic t_long_wait;
        fill(32'h0000_5550, mk(2), 4, "R11");
        hit(32'h0000_5558, mk(2), "R11");
    endtask

    task automatic t_conflict;
        fill(32'h0000_1630, mk(3), 0, "R5");
        fill(32'h0000_1230, mk(4), 1, "R5");
        fill(32'h0000_1638, mk(5), 0, "R5");
    endtask

    task automatic t_stray;
        @(negedge clk);
        refill_valid = 1'b1;
        refill_data  = mk(6);
        @(negedge clk);
        refill_valid = 1'b0;
        #2;
        chk(!refill_req, "R12", 128'(refill_req), 128'(0));
        fill(32'h0000_2000, mk(7), 0, "R12");
    endtask

    task automatic t_par_single(input int b);
        inject(32'h0000_2000, b);
        exp_cnt++;
        fill(32'h0000_2004, mk(7), 1, "R7");
        hit(32'h0000_2000, mk(7), "R8");
    endtask

    task automatic t_par_both;
        inject(32'h0000_2000, 3);
        inject(32'h0000_2000, 70);
        exp_cnt++;
        fill(32'h0000_2000, mk(7), 0, "R9");
        hit(32'h0000_2008, mk(7), "R9");
    endtask

    task automatic t_par_same_half;
        logic [127:0] bad;
        bad = mk(7);
        bad[3] = ~bad[3];
        bad[9] = ~bad[9];
        inject(32'h0000_2000, 3);
        inject(32'h0000_2000, 9);
        hit(32'h0000_2000, bad, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold();
        t_long_wait();
        t_conflict();
        t_stray();
        t_par_single(5);
        t_par_single(100);
        t_par_both();
        t_par_same_half();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule